// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a 32-bit interval timer with a single interrupt line. It sits on a simple one-cycle register bus and holds five word registers: control, status, load value, compare value and a read-only counter. The counter counts down, one step for each tick of one of three tick-enable inputs that run on the bus clock. When it reaches zero, it either reloads from the load register or wraps to all ones. On the tick where the counter equals the compare value, a sticky event flag is set. Software clears that flag by writing a one to it. The interrupt output is the flag gated by an enable bit.

Software uses the timer in two ways. The first is as a free-running time base: the load value is all ones, reload is selected, and the inverted count is read back. The second is as a one-shot or periodic event source: software clears the run bit, writes a new load value and sets the run bit again, with reload-on-enable selected so that the new interval starts cleanly. A self-clearing soft reset puts the counting state back to a known state and keeps the mode settings.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset, control, status, load and compare read 0, the counter reads 0xFFFFFFFF, and `irq` is 0.
- R2: The word registers are at byte offsets 0x00 control, 0x04 status, 0x08 load, 0x0C compare and 0x10 counter. Writes to the counter offset are ignored. Reads of any other offset, and `bus_rdata` when no read is in progress, return 0.
- R3: When control bit 0 (run) is 1 and the clock-select field in control bits 25:24 is n (1 to 3), the counter drops by one on each cycle where `tick_en[n-1]` is 1. A select value of 0 stops counting, and the other tick inputs have no effect.
- R4: A tick at count 0 loads the load register when control bit 3 is 1, and loads 0xFFFFFFFF when control bit 3 is 0.
- R5: A control write that changes bit 0 from 0 to 1 while it also sets bit 1 copies the load register into the counter.
- R6: When control bit 17 is 1, a write to the load register also writes the same value into the counter. When bit 17 is 0, the counter is left unchanged.
- R7: The event flag (status bit 0) is set on any tick where the counter equals the compare register.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a clear and a new match happen in the same cycle, the flag ends up set.
- R9: `irq` equals the event flag ANDed with control bit 2.
- R10: Writing control with bit 16 set starts a soft reset. It clears the run bit and the flag, forces the counter to 0xFFFFFFFF and keeps the other written control bits. Bit 16 reads 1 for the 4 cycles after the write and then 0, and any bus write made during those cycles is ignored.
- R11: Control bits 21, 19 and 18 are stored and read back, and they have no effect on counting.
- R12: While the run bit is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| tick_en | input | 3 | Tick enables of the three counting sources, synchronous to `clk` |
| irq | output | 1 | Compare interrupt |

## Verification
Assertions check the following on every cycle: the one-step decrement, the counter holding when the timer is stopped or unclocked, the zero-crossing choice between reload and wrap, a compare match always leaving the flag set, the flag staying set until it is cleared, and the soft reset forcing the counter to all ones while blocking writes. Some behaviour is only visible through the bench's scenarios. This covers how a count seen at the bus turns into read data, the exact four-cycle length of the busy bit, the reload on a rising run bit, the load-through write, and the agreement between random bus traffic and an independent reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control-bit positions software decodes
  localparam int unsigned B_RUN      = 0;
  localparam int unsigned B_RLD_EN   = 1;
  localparam int unsigned B_IRQ_EN   = 2;
  localparam int unsigned B_RLD_ZERO = 3;
  localparam int unsigned B_SRST     = 16;
  localparam int unsigned B_LD_THRU  = 17;
  localparam int unsigned B_KEEP_DBG = 18;
  localparam int unsigned B_KEEP_WT  = 19;
  localparam int unsigned B_KEEP_STP = 21;
  localparam int unsigned B_CSEL_LO  = 24;
  localparam int unsigned CSEL_W     = 2;
  localparam int unsigned NUM_SRC    = (1 << CSEL_W) - 1;

  // Byte offsets of the word registers
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_STAT = 'h04;
  localparam int unsigned OFF_LOAD = 'h08;
  localparam int unsigned OFF_CMP  = 'h0C;
  localparam int unsigned OFF_CNT  = 'h10;

  typedef struct packed {
    logic              run;
    logic              reload_on_en;
    logic              irq_en;
    logic              reload_zero;
    logic              load_thru;
    logic              keep_dbg;
    logic              keep_wait;
    logic              keep_stop;
    logic [CSEL_W-1:0] csel;
  } ctl_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic              flag_q,
  output ctl_t              ctl_q,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              srst_hold,
  output logic              en_rise,
  output logic              ld_wr,
  output logic              sts_clr
);
  localparam int unsigned SR_W = $clog2(SRST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFF_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);

  logic [SR_W-1:0]   sr_q, sr_d;
  ctl_t              ctl_d;
  logic [DATA_W-1:0] load_d, cmp_d;
  logic              busy, wr_ok, wr_ctl, wr_stat, wr_load, wr_cmp, srst_start;

  assign busy    = (sr_q != '0);
  assign wr_ok   = bus_valid && bus_write && !busy;
  assign wr_ctl  = wr_ok && (bus_addr == A_CTRL);
  assign wr_stat = wr_ok && (bus_addr == A_STAT);
  assign wr_load = wr_ok && (bus_addr == A_LOAD);
  assign wr_cmp  = wr_ok && (bus_addr == A_CMP);

  assign srst_start = wr_ctl && bus_wdata[B_SRST];
  assign srst_hold  = srst_start || busy;
  assign en_rise    = wr_ctl && !bus_wdata[B_SRST] && bus_wdata[B_RUN]
                      && bus_wdata[B_RLD_EN] && !ctl_q.run;
  assign ld_wr      = wr_load && ctl_q.load_thru;
  assign sts_clr    = wr_stat && bus_wdata[0];

  // Next-state
  always_comb begin
    ctl_d  = ctl_q;
    load_d = load_q;
    cmp_d  = cmp_q;
    sr_d   = busy ? sr_q - 1'b1 : sr_q;
    if (wr_ctl) begin
      ctl_d.run          = bus_wdata[B_RUN] && !bus_wdata[B_SRST];
      ctl_d.reload_on_en = bus_wdata[B_RLD_EN];
      ctl_d.irq_en       = bus_wdata[B_IRQ_EN];
      ctl_d.reload_zero  = bus_wdata[B_RLD_ZERO];
      ctl_d.load_thru    = bus_wdata[B_LD_THRU];
      ctl_d.keep_dbg     = bus_wdata[B_KEEP_DBG];
      ctl_d.keep_wait    = bus_wdata[B_KEEP_WT];
      ctl_d.keep_stop    = bus_wdata[B_KEEP_STP];
      ctl_d.csel         = bus_wdata[B_CSEL_LO +: CSEL_W];
    end
    if (srst_start) sr_d   = SR_W'(SRST_CYCLES);
    if (wr_load)    load_d = bus_wdata;
    if (wr_cmp)     cmp_d  = bus_wdata;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      sr_q   <= '0;
    end else begin
      ctl_q  <= ctl_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
      sr_q   <= sr_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      unique case (bus_addr)
        A_CTRL: begin
          bus_rdata[B_RUN]      = ctl_q.run;
          bus_rdata[B_RLD_EN]   = ctl_q.reload_on_en;
          bus_rdata[B_IRQ_EN]   = ctl_q.irq_en;
          bus_rdata[B_RLD_ZERO] = ctl_q.reload_zero;
          bus_rdata[B_SRST]     = busy;
          bus_rdata[B_LD_THRU]  = ctl_q.load_thru;
          bus_rdata[B_KEEP_DBG] = ctl_q.keep_dbg;
          bus_rdata[B_KEEP_WT]  = ctl_q.keep_wait;
          bus_rdata[B_KEEP_STP] = ctl_q.keep_stop;
          bus_rdata[B_CSEL_LO +: CSEL_W] = ctl_q.csel;
        end
        A_STAT:  bus_rdata[0] = flag_q;
        A_LOAD:  bus_rdata = load_q;
        A_CMP:   bus_rdata = cmp_q;
        A_CNT:   bus_rdata = cnt_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_SRST_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_valid && bus_write) |=> ($stable(load_q) && $stable(cmp_q) && $stable(ctl_q))); // R10
  AST_SRST_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    srst_start |=> !ctl_q.run); // R10
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_en,
  input  ctl_t               ctl_q,
  input  logic [DATA_W-1:0]  load_q,
  input  logic [DATA_W-1:0]  cmp_q,
  input  logic               srst_hold,
  input  logic               en_rise,
  input  logic               ld_wr,
  input  logic [DATA_W-1:0]  ld_val,
  input  logic               sts_clr,
  output logic [DATA_W-1:0]  cnt_q,
  output logic               flag_q,
  output logic               irq
);
  logic [NUM_SRC-1:0] src_hit;
  logic [DATA_W-1:0]  cnt_d;
  logic               flag_d, tick, match;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = tick_en[i] && (ctl_q.csel == CSEL_W'(i + 1));
  end

  assign tick  = ctl_q.run && (|src_hit) && !srst_hold;
  assign match = tick && (cnt_q == cmp_q);

  // Next-state
  always_comb begin
    cnt_d = cnt_q;
    if (srst_hold)    cnt_d = '1;
    else if (en_rise) cnt_d = load_q;
    else if (ld_wr)   cnt_d = ld_val;
    else if (tick)    cnt_d = (cnt_q == '0) ? (ctl_q.reload_zero ? load_q : '1)
                                            : cnt_q - 1'b1;
    flag_d = flag_q;
    if (srst_hold)    flag_d = 1'b0;
    else if (match)   flag_d = 1'b1;
    else if (sts_clr) flag_d = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q && ctl_q.irq_en;

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !en_rise && !ld_wr) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_NO_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.csel == '0 && !srst_hold && !en_rise && !ld_wr) |=> $stable(cnt_q)); // R3
  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !ctl_q.reload_zero && !en_rise && !ld_wr) |=> (cnt_q == '1)); // R4
  AST_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && ctl_q.reload_zero && !en_rise && !ld_wr) |=> (cnt_q == $past(load_q))); // R4
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sts_clr && !srst_hold) |=> flag_q); // R8
  AST_SRST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hold |=> (cnt_q == '1 && !flag_q)); // R10
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.run && !srst_hold && !en_rise && !ld_wr) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SRST_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tick_en,
  output logic               irq
);
  logic              rst_n_s;
  ctl_t              ctl_q;
  logic [DATA_W-1:0] load_q, cmp_q, cnt_q;
  logic              flag_q, srst_hold, en_rise, ld_wr, sts_clr;

  tmr_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  tmr_regs #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SRST_CYCLES (SRST_CYCLES)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .ctl_q     (ctl_q),
    .load_q    (load_q),
    .cmp_q     (cmp_q),
    .srst_hold (srst_hold),
    .en_rise   (en_rise),
    .ld_wr     (ld_wr),
    .sts_clr   (sts_clr)
  );

  tmr_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_en   (tick_en),
    .ctl_q     (ctl_q),
    .load_q    (load_q),
    .cmp_q     (cmp_q),
    .srst_hold (srst_hold),
    .en_rise   (en_rise),
    .ld_wr     (ld_wr),
    .ld_val    (bus_wdata),
    .sts_clr   (sts_clr),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .irq       (irq)
  );

  AST_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!flag_q && !ctl_q.irq_en) |-> !irq); // R9
endmodule

// File: tb/sim_tmr_down_timer.sv
module sim_tmr_down_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  tick_en;
  logic        irq;

  int unsigned n_chk = 0, n_err = 0;
  bit          done = 1'b0;
  logic [31:0] rd;

  // Reference model state
  logic [31:0] m_ctl, m_ld, m_cmp, m_cnt;
  logic        m_flag;
  int          m_sr;

  localparam logic [31:0] CTL_MASK = 32'h032E_000F;

  always #2 clk = ~clk;

  tmr_down_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00:   return m_ctl | ((m_sr != 0) ? 32'h0001_0000 : 32'h0);
      5'h04:   return {31'h0, m_flag};
      5'h08:   return m_ld;
      5'h0C:   return m_cmp;
      5'h10:   return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00:   return "R11 ctrl read";
      5'h04:   return "R7 status read";
      5'h08:   return "R6 load read";
      5'h0C:   return "R7 compare read";
      5'h10:   return "R3 counter read";
      default: return "R2 unmapped read";
    endcase
  endfunction

  task automatic cyc(input bit v, input bit w, input logic [4:0] a,
                     input logic [31:0] d, input logic [2:0] tk);
    logic [31:0] n_ctl, n_ld, n_cmp, n_cnt;
    logic        n_flag, tick, match;
    int          n_sr, sel;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1;
    if (v && !w) begin
      rd = bus_rdata;
      chk(tag_of(a), rd, m_read(a));
    end else chk("R2 idle rdata", bus_rdata, 32'h0);
    chk("R9 irq", {31'h0, irq}, {31'h0, m_flag & m_ctl[2]});
    // model next state
    n_ctl = m_ctl; n_ld = m_ld; n_cmp = m_cmp; n_cnt = m_cnt; n_flag = m_flag; n_sr = m_sr;
    if (m_sr != 0) begin
      n_sr = m_sr - 1; n_cnt = '1; n_flag = 1'b0;
    end else begin
      sel   = int'(m_ctl[25:24]);
      tick  = m_ctl[0] && sel != 0 && tk[sel-1];
      match = tick && (m_cnt == m_cmp);
      if (tick) n_cnt = (m_cnt == 0) ? (m_ctl[3] ? m_ld : 32'hFFFF_FFFF) : m_cnt - 1;
      if (match) n_flag = 1'b1;
      else if (v && w && a == 5'h04 && d[0]) n_flag = 1'b0;
      if (v && w && a == 5'h00) begin
        if (d[16]) begin
          n_ctl = d & CTL_MASK & ~32'h1; n_sr = 4; n_cnt = '1; n_flag = 1'b0;
        end else begin
          n_ctl = d & CTL_MASK;
          if (d[0] && d[1] && !m_ctl[0]) n_cnt = m_ld;
        end
      end
      if (v && w && a == 5'h08) begin
        n_ld = d;
        if (m_ctl[17]) n_cnt = d;
      end
      if (v && w && a == 5'h0C) n_cmp = d;
    end
    @(posedge clk); #1;
    m_ctl = n_ctl; m_ld = n_ld; m_cmp = n_cmp; m_cnt = n_cnt; m_flag = n_flag; m_sr = n_sr;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d); cyc(1, 1, a, d, 3'b000); endtask
  task automatic rdr(input logic [4:0] a);                      cyc(1, 0, a, 0, 3'b000); endtask
  task automatic tk(input logic [2:0] t, input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, t);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0; tick_en = 0; rd = 0;
    m_ctl = 0; m_ld = 0; m_cmp = 0; m_cnt = '1; m_flag = 0; m_sr = 0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    tk(3'b000, 3);

    // R1 reset values, R2 unmapped offset
    rdr(5'h00); chk("R1 ctrl", rd, 32'h0);
    rdr(5'h04); chk("R1 status", rd, 32'h0);
    rdr(5'h08); chk("R1 load", rd, 32'h0);
    rdr(5'h0C); chk("R1 compare", rd, 32'h0);
    rdr(5'h10); chk("R1 counter", rd, 32'hFFFF_FFFF);
    rdr(5'h14); chk("R2 unmapped", rd, 32'h0);
    wr(5'h10, 32'h1234); rdr(5'h10); chk("R2 counter write ignored", rd, 32'hFFFF_FFFF);

    // R5 reload on enable, R3 counting on source 1
    wr(5'h08, 32'd5);
    wr(5'h00, 32'h0100_000B);
    rdr(5'h10); chk("R5 reload on enable", rd, 32'd5);
    tk(3'b001, 3); rdr(5'h10); chk("R3 decrement", rd, 32'd2);
    tk(3'b110, 2); rdr(5'h10); chk("R3 other sources ignored", rd, 32'd2);
    tk(3'b001, 3); rdr(5'h10); chk("R4 reload at zero", rd, 32'd5);
    rdr(5'h04); chk("R7 flag at match", rd, 32'd1);
    chk("R9 irq masked", {31'h0, irq}, 32'd0);

    // R8 write 0 no effect, R9 irq enable, W1C
    wr(5'h04, 32'h0); rdr(5'h04); chk("R8 write zero keeps flag", rd, 32'd1);
    wr(5'h00, 32'h0100_000F); chk("R9 irq enabled", {31'h0, irq}, 32'd1);
    wr(5'h04, 32'h1); rdr(5'h04); chk("R8 w1c clears", rd, 32'd0);
    chk("R9 irq drops", {31'h0, irq}, 32'd0);

    // R8 set wins over clear
    wr(5'h0C, 32'd3);
    tk(3'b001, 2);
    cyc(1, 1, 5'h04, 32'h1, 3'b001);
    rdr(5'h04); chk("R8 set wins", rd, 32'd1);
    rdr(5'h10); chk("R3 count after match", rd, 32'd2);

    // R12 disable holds
    wr(5'h00, 32'h0100_000E);
    tk(3'b111, 3); rdr(5'h10); chk("R12 stopped holds", rd, 32'd2);

    // R6 no load-through, R4 wrap
    wr(5'h08, 32'd1); rdr(5'h10); chk("R6 load without through", rd, 32'd2);
    wr(5'h00, 32'h0100_0003);
    tk(3'b001, 2); rdr(5'h10); chk("R4 wrap to ones", rd, 32'hFFFF_FFFF);

    // R6 load-through
    wr(5'h00, 32'h0102_0003);
    wr(5'h08, 32'h40); rdr(5'h10); chk("R6 load through", rd, 32'h40);

    // R3 select 0 stops
    wr(5'h00, 32'h0002_0001);
    tk(3'b111, 3); rdr(5'h10); chk("R3 select zero", rd, 32'h40);

    // R11 stored mode bits
    wr(5'h00, 32'h012C_0001);
    rdr(5'h00); chk("R11 mode bits", rd, 32'h012C_0001);
    tk(3'b001, 2); rdr(5'h10); chk("R11 still counts", rd, 32'h3E);

    // R10 soft reset
    wr(5'h00, 32'h0101_0009);
    rdr(5'h00); chk("R10 busy 1", rd, 32'h0101_0008);
    wr(5'h08, 32'h77);
    rdr(5'h00); chk("R10 busy 3", rd, 32'h0101_0008);
    rdr(5'h00); chk("R10 busy 4", rd, 32'h0101_0008);
    rdr(5'h00); chk("R10 done", rd, 32'h0100_0008);
    rdr(5'h08); chk("R10 write ignored", rd, 32'h40);
    rdr(5'h04); chk("R10 flag cleared", rd, 32'h0);
    rdr(5'h10); chk("R10 counter ones", rd, 32'hFFFF_FFFF);

    // Random traffic against the model
    seed_dummy = $urandom(32'h5EED_1234);
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      int unsigned r;
      r = $urandom % 7;
      a = (r < 5) ? 5'(r * 4) : ((r == 5) ? 5'h14 : 5'h1C);
      d = $urandom;
      if (a == 5'h00) begin
        d = d & 32'h032E_000F;
        if ($urandom % 16 == 0) d[16] = 1'b1;
      end else if (a == 5'h08 || a == 5'h0C) d = d % 12;
      if ($urandom % 3 == 0) cyc(1, ($urandom % 2) == 1, a, d, 3'($urandom));
      else cyc(0, 0, 0, 0, 3'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule